// File: doc/BRIEF.md
# Sector Block Transfer Checker

This block sits in front of a sector-organized memory. It screens single-block and multi-block read and write requests against the memory's alignment and length rules. A request comes in on a valid/ready command port and carries a direction, a single-or-multi flag, a start byte address and a block length. The block checks the request in the cycle it is accepted. A request that breaks a rule is refused with an error pulse, and no block address goes out. An accepted request produces a stream of block start addresses, one per block.

For each block, the block counts the data bytes that the surrounding datapath moves. It pulses a done marker after the last data byte, then holds a CRC-phase flag while the two check bytes pass. In multi-block mode it moves the address forward by one block length after each block. Every new read block is checked again against the sector boundary. The run ends after the block during which a stop request arrived. CRC arithmetic, the memory access and bus serialization are handled elsewhere.

There are three handshakes, and each can apply back-pressure:
- A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle.
- A block address on `blk_valid` stays valid and unchanged until `blk_ready` is seen.
- A byte beat counts only when `beat_valid` and `beat_ready` are both high. Beats may have gaps between them.

Top module: `sector_xfer_chk`

## Requirements
- R1: A write is accepted only if its length equals the sector size (512 bytes by default) and its start address has all offset bits (address bits [8:0] by default) at zero. A wrong length raises `len_err`, a nonzero offset raises `misalign_err`, and both may be raised together.
- R2: A read length of 0, or a read length greater than the sector size, raises `len_err`. Lengths from 1 up to the sector size pass the length rule.
- R3: A read with a valid length raises `misalign_err` when its address offset plus its length exceeds the sector size. This is the case where the block would cross into the next sector.
- R4: An error flag is a one-cycle pulse, in the cycle after the command handshake. After a rejected request, `blk_valid` stays low and `cmd_ready` stays high.
- R5: After an accepted command, `blk_valid` rises in the next cycle, with `blk_addr` equal to the command address and `blk_write` equal to the direction (1 = write). Both are held stable until `blk_ready` is high.
- R6: After a block address is taken, `beat_ready` is high and exactly `len` data beats are counted. `block_done` pulses for one cycle, in the cycle after the last data beat. `crc_phase` is high from that cycle through the two CRC beats that follow.
- R7: In single-block mode, the block returns to idle in the cycle after the second CRC beat, with `cmd_ready` high and `crc_phase` low.
- R8: In multi-block mode, the next block address is the previous one plus the block length. It is presented in the cycle after the second CRC beat.
- R9: A `stop_req` pulse received while a transfer is active ends the transfer after the CRC of the current block. A `stop_req` received while idle has no effect.
- R10: In a multi-block read, if the next block would cross a sector boundary, the block pulses `misalign_err` in the cycle after the second CRC beat, returns to idle and issues no further address.
- R11: During reset and directly after it, `cmd_ready` is 1, and `blk_valid`, `beat_ready`, `crc_phase`, `block_done`, `misalign_err` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (block idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_multi | input | 1 | 1 = multi-block, 0 = single block |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Block length in bytes |
| stop_req | input | 1 | Stop-transmission pulse |
| blk_valid | output | 1 | Block start address valid |
| blk_ready | input | 1 | Block start address taken |
| blk_addr | output | ADDR_W | Block start byte address |
| blk_write | output | 1 | Direction of the current block |
| beat_valid | input | 1 | A byte is offered by the datapath |
| beat_ready | output | 1 | Bytes are counted (data or CRC phase) |
| crc_phase | output | 1 | The two CRC bytes are due |
| block_done | output | 1 | Pulse after the last data byte of a block |
| misalign_err | output | 1 | Alignment or sector-crossing error pulse |
| len_err | output | 1 | Length error pulse |

## Verification
Timing is counted from the clock edge on which each event happens:
- The error flags and the first block address are due one cycle after the command handshake edge.
- `block_done` and `crc_phase` are due one cycle after the edge that takes the last data beat.
- The return to idle, the next address or a mid-run `misalign_err` is due one cycle after the second CRC beat.

The bench drives all inputs on the falling clock edge. One task advances exactly one rising edge and comes back to the falling edge. Each check is made at the falling edge that follows the rising edge on which the result is due. Beat gaps and address stalls are added as extra steps, so every expected result stays tied to the edge of its handshake.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DATA  = 2'd2,
    ST_CRC   = 2'd3
  } sbt_state_e;

  localparam int CRC_BYTES = 2;
endpackage

// File: rtl/sbt_rule_check.sv
// Combinational alignment and length screen for one block.
module sbt_rule_check #(
  parameter int SECTOR_BYTES = 512,
  localparam int OFF_W = $clog2(SECTOR_BYTES),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic             is_write,
  input  logic [OFF_W-1:0] off,
  input  logic [LEN_W-1:0] len,
  output logic             len_bad,
  output logic             align_bad
);
  localparam logic [LEN_W:0] SECT_X = (LEN_W+1)'(SECTOR_BYTES);

  logic [LEN_W:0] span;
  logic           rd_len_bad;

  assign span       = (LEN_W+1)'(off) + {1'b0, len};
  assign rd_len_bad = (len == '0) || ({1'b0, len} > SECT_X);

  always_comb begin
    if (is_write) begin
      len_bad   = ({1'b0, len} != SECT_X);
      align_bad = (off != '0);
    end else begin
      len_bad   = rd_len_bad;
      align_bad = !rd_len_bad && (span > SECT_X);
    end
  end
endmodule

// File: rtl/sbt_beat_count.sv
// Counts accepted beats within the data phase and the CRC phase.
module sbt_beat_count #(
  parameter int LEN_W = 10,
  parameter int CRC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             in_data,
  input  logic             in_crc,
  input  logic [LEN_W-1:0] len,
  output logic             data_last,
  output logic             crc_last
);
  localparam logic [LEN_W-1:0] CRC_LAST = LEN_W'(CRC_BYTES - 1);

  logic [LEN_W-1:0] cnt;

  assign data_last = beat && in_data && (cnt == (len - 1'b1));
  assign crc_last  = beat && in_crc  && (cnt == CRC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (data_last || crc_last)  cnt <= '0;
    else if (beat)                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbt_sequencer.sv
// Request state machine: acceptance, address stepping, stop and abort.
module sbt_sequencer
  import sbt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              cmd_write,
  input  logic              cmd_multi,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_len_bad,
  input  logic              cmd_align_bad,
  input  logic              nxt_align_bad,
  input  logic              stop_req,
  input  logic              blk_ready,
  input  logic              data_last,
  input  logic              crc_last,
  output sbt_state_e        state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [LEN_W-1:0]  len_q,
  output logic              write_q,
  output logic              misalign_err,
  output logic              len_err,
  output logic              block_done
);
  logic multi_q;
  logic stop_q;
  logic finish;
  logic cmd_ok;

  assign nxt_addr = cur_addr + ADDR_W'(len_q);
  assign finish   = !multi_q || stop_q || stop_req;
  assign cmd_ok   = !cmd_len_bad && !cmd_align_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      len_q    <= '0;
      write_q  <= 1'b0;
      multi_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_fire) begin
            cur_addr <= cmd_addr;
            len_q    <= cmd_len;
            write_q  <= cmd_write;
            multi_q  <= cmd_multi;
            if (cmd_ok) state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (blk_ready) state <= ST_DATA;
        end
        ST_DATA: begin
          if (data_last) state <= ST_CRC;
        end
        ST_CRC: begin
          if (crc_last) begin
            if (finish || nxt_align_bad) begin
              state <= ST_IDLE;
            end else begin
              cur_addr <= nxt_addr;
              state    <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                stop_q <= 1'b0;
    else if (state == ST_IDLE) stop_q <= 1'b0;
    else if (stop_req)         stop_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misalign_err <= 1'b0;
      len_err      <= 1'b0;
      block_done   <= 1'b0;
    end else begin
      len_err      <= cmd_fire && cmd_len_bad;
      misalign_err <= (cmd_fire && cmd_align_bad) ||
                      ((state == ST_CRC) && crc_last && !finish && nxt_align_bad);
      block_done   <= data_last;
    end
  end
endmodule

// File: rtl/sector_xfer_chk.sv
module sector_xfer_chk
  import sbt_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W = 32,
  localparam int OFF_W = $clog2(SECTOR_BYTES),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_multi,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              stop_req,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              blk_write,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic              crc_phase,
  output logic              block_done,
  output logic              misalign_err,
  output logic              len_err
);
  sbt_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [LEN_W-1:0]  len_q;
  logic              write_q;
  logic              cmd_fire;
  logic              cmd_len_bad, cmd_align_bad;
  logic              nxt_len_bad, nxt_align_bad;
  logic              data_last, crc_last;
  logic              beat;

  assign cmd_ready  = (state == ST_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign blk_valid  = (state == ST_ISSUE);
  assign blk_addr   = cur_addr;
  assign blk_write  = write_q;
  assign beat_ready = (state == ST_DATA) || (state == ST_CRC);
  assign crc_phase  = (state == ST_CRC);
  assign beat       = beat_valid && beat_ready;

  sbt_rule_check #(.SECTOR_BYTES(SECTOR_BYTES)) u_cmd_rule (
    .is_write  (cmd_write),
    .off       (cmd_addr[OFF_W-1:0]),
    .len       (cmd_len),
    .len_bad   (cmd_len_bad),
    .align_bad (cmd_align_bad)
  );

  sbt_rule_check #(.SECTOR_BYTES(SECTOR_BYTES)) u_nxt_rule (
    .is_write  (write_q),
    .off       (nxt_addr[OFF_W-1:0]),
    .len       (len_q),
    .len_bad   (nxt_len_bad),
    .align_bad (nxt_align_bad)
  );

  sbt_beat_count #(.LEN_W(LEN_W), .CRC_BYTES(CRC_BYTES)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .in_data   (state == ST_DATA),
    .in_crc    (state == ST_CRC),
    .len       (len_q),
    .data_last (data_last),
    .crc_last  (crc_last)
  );

  sbt_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_fire      (cmd_fire),
    .cmd_write     (cmd_write),
    .cmd_multi     (cmd_multi),
    .cmd_addr      (cmd_addr),
    .cmd_len       (cmd_len),
    .cmd_len_bad   (cmd_len_bad),
    .cmd_align_bad (cmd_align_bad),
    .nxt_align_bad (nxt_align_bad || nxt_len_bad),
    .stop_req      (stop_req),
    .blk_ready     (blk_ready),
    .data_last     (data_last),
    .crc_last      (crc_last),
    .state         (state),
    .cur_addr      (cur_addr),
    .nxt_addr      (nxt_addr),
    .len_q         (len_q),
    .write_q       (write_q),
    .misalign_err  (misalign_err),
    .len_err       (len_err),
    .block_done    (block_done)
  );
endmodule

// File: rtl/sector_xfer_chk_sva.sv
module sector_xfer_chk_sva #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W = 32,
  localparam int OFF_W = $clog2(SECTOR_BYTES),
  localparam int LEN_W = OFF_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              blk_valid,
  input logic              blk_ready,
  input logic [ADDR_W-1:0] blk_addr,
  input logic              blk_write,
  input logic              beat_ready,
  input logic              crc_phase,
  input logic              block_done,
  input logic              misalign_err,
  input logic              len_err,
  input logic [LEN_W-1:0]  len_q
);
  localparam logic [LEN_W:0] SECT_X = (LEN_W+1)'(SECTOR_BYTES);

  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_write |-> (blk_addr[OFF_W-1:0] == '0) && ({1'b0, len_q} == SECT_X)); // R1

  AST_LEN_ERR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(cmd_valid && cmd_ready)); // R2

  AST_READ_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_write |-> ((LEN_W+1)'(blk_addr[OFF_W-1:0]) + (LEN_W+1)'(len_q)) <= SECT_X); // R3

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err || misalign_err) |-> cmd_ready && !blk_valid); // R4

  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_addr)); // R5

  AST_DONE_IN_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> crc_phase && $past(beat_ready)); // R6

  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && $past(crc_phase) |-> blk_addr == $past(blk_addr) + ADDR_W'($past(len_q))); // R8
endmodule

bind sector_xfer_chk sector_xfer_chk_sva #(.SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .blk_valid    (blk_valid),
  .blk_ready    (blk_ready),
  .blk_addr     (blk_addr),
  .blk_write    (blk_write),
  .beat_ready   (beat_ready),
  .crc_phase    (crc_phase),
  .block_done   (block_done),
  .misalign_err (misalign_err),
  .len_err      (len_err),
  .len_q        (len_q)
);

// File: tb/tb_sector_xfer_chk.sv
module tb_sector_xfer_chk;
  localparam int SECT = 16;
  localparam int AW   = 16;
  localparam int LW   = $clog2(SECT) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0, cmd_multi = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          stop_req = 1'b0, blk_ready = 1'b0, beat_valid = 1'b0;
  logic          cmd_ready, blk_valid, blk_write, beat_ready;
  logic          crc_phase, block_done, misalign_err, len_err;
  logic [AW-1:0] blk_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sector_xfer_chk #(.SECTOR_BYTES(SECT), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_multi(cmd_multi), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .stop_req(stop_req), .blk_valid(blk_valid),
    .blk_ready(blk_ready), .blk_addr(blk_addr), .blk_write(blk_write),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .crc_phase(crc_phase),
    .block_done(block_done), .misalign_err(misalign_err), .len_err(len_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit exp_len_bad(bit w, int len);
    if (w) return len != SECT;
    return (len == 0) || (len > SECT);
  endfunction

  function automatic bit exp_mis(bit w, int addr, int len);
    if (w) return (addr % SECT) != 0;
    return !exp_len_bad(w, len) && ((addr % SECT) + len > SECT);
  endfunction

  // stop_blk < 0: no stop; otherwise stop pulsed on first data beat of that block
  task automatic run_xfer(bit w, bit m, int addr, int len, int stop_blk);
    int a;
    int blk;
    bit lb, mb, fin;
    chk("R4 cmd_ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = w; cmd_multi = m;
    cmd_addr = AW'(addr); cmd_len = LW'(len);
    step();
    cmd_valid = 1'b0;
    lb = exp_len_bad(w, len);
    mb = exp_mis(w, addr, len);
    chk(w ? "R1 len_err" : "R2 len_err", len_err, lb);
    chk(w ? "R1 misalign_err" : "R3 misalign_err", misalign_err, mb);
    if (lb || mb) begin
      chk("R4 no block after error", blk_valid, 0);
      chk("R4 cmd_ready after error", cmd_ready, 1);
      step();
      chk("R4 error is one pulse", len_err | misalign_err, 0);
      return;
    end
    a = addr;
    blk = 0;
    forever begin
      chk("R5 blk_valid", blk_valid, 1);
      chk(blk == 0 ? "R5 blk_addr" : "R8 blk_addr", blk_addr, a % (1 << AW));
      chk("R5 blk_write", blk_write, w);
      if (blk == 0 && addr[0]) begin
        step();
        chk("R5 held under back-pressure", blk_valid, 1);
        chk("R5 addr stable", blk_addr, a % (1 << AW));
      end
      blk_ready = 1'b1;
      step();
      blk_ready = 1'b0;
      for (int i = 0; i < len; i++) begin
        chk("R6 beat_ready in data", beat_ready, 1);
        if (i == 1) begin
          beat_valid = 1'b0;
          step();
        end
        beat_valid = 1'b1;
        if (blk == stop_blk && i == 0) stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        beat_valid = 1'b0;
        if (i < len - 1) chk("R6 no early block_done", block_done, 0);
      end
      chk("R6 block_done after last byte", block_done, 1);
      chk("R6 crc_phase first", crc_phase, 1);
      beat_valid = 1'b1;
      step();
      chk("R6 block_done one pulse", block_done, 0);
      chk("R6 crc_phase second", crc_phase, 1);
      step();
      beat_valid = 1'b0;
      fin = !m || (stop_blk >= 0 && blk >= stop_blk);
      if (fin) begin
        chk(m ? "R9 idle after stop" : "R7 idle after single", cmd_ready, 1);
        chk("R7 crc_phase low", crc_phase, 0);
        chk("R7 no further block", blk_valid, 0);
        return;
      end
      a = a + len;
      if (!w && ((a % SECT) + len > SECT)) begin
        chk("R10 misalign on crossing block", misalign_err, 1);
        chk("R10 idle after abort", cmd_ready, 1);
        chk("R10 no further block", blk_valid, 0);
        step();
        chk("R10 error one pulse", misalign_err, 0);
        return;
      end
      blk++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R11 cmd_ready in reset", cmd_ready, 1);
    step();
    step();
    rst_n = 1'b1;
    step();
    chk("R11 cmd_ready", cmd_ready, 1);
    chk("R11 blk_valid", blk_valid, 0);
    chk("R11 beat_ready", beat_ready, 0);
    chk("R11 crc_phase", crc_phase, 0);
    chk("R11 block_done", block_done, 0);
    chk("R11 errors", misalign_err | len_err, 0);

    // Sweep every offset and every length for both directions, single block
    for (int w = 0; w < 2; w++)
      for (int off = 0; off < SECT; off++)
        for (int len = 0; len <= SECT + 4; len++)
          run_xfer(w[0], 1'b0, 2 * SECT + off, len, -1);

    // Stop while idle is ignored: multi write keeps going past block 0
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk("R9 stop in idle no effect", cmd_ready, 1);
    run_xfer(1'b1, 1'b1, 4 * SECT, SECT, 2);

    // Multi reads
    run_xfer(1'b0, 1'b1, 2, 5, -1);
    run_xfer(1'b0, 1'b1, 0, SECT, 3);
    run_xfer(1'b0, 1'b1, 4, 4, 1);
    run_xfer(1'b0, 1'b1, SECT + 1, 3, -1);
    run_xfer(1'b1, 1'b1, 0, SECT, 0);

    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule